// File: doc/BRIEF.md
# Secure-Banked Interrupt Priority Mask

This block holds the 8-bit priority mask of one CPU interface. Interrupts whose priority value is not below the mask are held back by the interrupt signalling logic, which reads the mask from the `mask_q` output. Software reaches the register through a single-cycle access port. Each access carries three attributes: whether it comes from non-secure software, whether the highest exception level is implemented, and whether the routing bit is set that reserves Group 0 for secure software.

When all three attributes hold, the access uses a translated view. Non-secure software then sees a halved copy of the priority space. Reads shift the stored value up by one bit. Writes shift the data down by one bit and place the result in the upper, non-secure half of the range. While the stored mask lies in the secure half, non-secure writes are dropped. Each write that the block accepts raises `upd_strobe` for one cycle, so that the interrupt signalling logic re-evaluates pending interrupts against the new mask.

Top module: `pmask_bank`

## Requirements
- R1: After a synchronous reset, `mask_q` is 0x00 and `upd_strobe` is low.
- R2: A write outside the translated view stores all 8 bits of `acc_wdata` unchanged. A read outside the translated view returns the stored value unchanged.
- R3: The translated view applies only when `acc_nonsecure`, `acc_el3_impl` and `acc_g0_secure` are all 1. If any one of them is 0, the access is a raw access.
- R4: A translated read returns 0x00 when bit 7 of the stored value is 0.
- R5: A translated read returns (stored << 1) truncated to 8 bits when bit 7 is 1 and the stored value is not 0xFF.
- R6: A translated read of a stored 0xFF returns 0xFF.
- R7: A translated write is ignored when bit 7 of the stored value is 0. The register keeps its value and no strobe is raised.
- R8: An accepted translated write stores {1'b1, wdata[7:1]}.
- R9: `upd_strobe` is high for exactly the cycle after each accepted write, and is low at all other times.
- R10: A read access, or a cycle with no access, leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| acc_nonsecure | input | 1 | The access comes from non-secure software |
| acc_el3_impl | input | 1 | The highest exception level is implemented |
| acc_g0_secure | input | 1 | The routing bit is set that makes Group 0 secure-only |
| rd_data | output | 8 | Read view of the mask under the current attributes (combinational) |
| mask_q | output | 8 | Stored mask, for the interrupt signalling logic |
| upd_strobe | output | 1 | One-cycle pulse after each accepted write |

## Verification
The bench builds the block with its default width of 8. At this width the secure/non-secure boundary at bit 7 and the 0xFF special case can be reached directly, so the seeded random accesses hit every combination of the three attributes many times. Directed accesses add the edge values 0x00, 0x7F, 0x80, 0xC3 and 0xFF. A write that is blocked can be told apart from one that is accepted only through `mask_q` and the presence or absence of the strobe.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
    localparam int PRIO_W_DEF = 8;

    typedef struct packed {
        logic nonsecure;
        logic el3_impl;
        logic g0_secure;
    } acc_attr_t;

    typedef enum logic [1:0] {
        VIEW_RAW   = 2'd0,
        VIEW_HIDE  = 2'd1,
        VIEW_SHIFT = 2'd2,
        VIEW_TOP   = 2'd3
    } rd_kind_e;
endpackage

// File: rtl/pmask_view_sel.sv
module pmask_view_sel
    import pmask_pkg::*;
(
    input  acc_attr_t attr,
    output logic      xlate
);
    always_comb begin
        xlate = attr.nonsecure && attr.el3_impl && attr.g0_secure;
    end
endmodule

// File: rtl/pmask_rd_path.sv
module pmask_rd_path
    import pmask_pkg::*;
#(
    parameter int W = PRIO_W_DEF
) (
    input  logic [W-1:0] cur,
    input  logic         xlate,
    output logic [W-1:0] rdata
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    rd_kind_e kind;

    always_comb begin
        if (!xlate)                 kind = VIEW_RAW;
        else if (!cur[W-1])         kind = VIEW_HIDE;
        else if (cur == ALL_ONES)   kind = VIEW_TOP;
        else                        kind = VIEW_SHIFT;
    end

    always_comb begin
        unique case (kind)
            VIEW_RAW:   rdata = cur;
            VIEW_HIDE:  rdata = '0;
            VIEW_TOP:   rdata = ALL_ONES;
            VIEW_SHIFT: rdata = {cur[W-2:0], 1'b0};
            default:    rdata = cur;
        endcase
    end
endmodule

// File: rtl/pmask_wr_path.sv
module pmask_wr_path
    import pmask_pkg::*;
#(
    parameter int W = PRIO_W_DEF
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  logic         we,
    input  logic         xlate,
    output logic         accept,
    output logic [W-1:0] nxt
);
    always_comb begin
        accept = we && (!xlate || cur[W-1]);
        nxt    = xlate ? {1'b1, wdata[W-1:1]} : wdata;
    end
endmodule

// File: rtl/pmask_bank.sv
module pmask_bank
    import pmask_pkg::*;
#(
    parameter int W = PRIO_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         acc_valid,
    input  logic         acc_write,
    input  logic [W-1:0] acc_wdata,
    input  logic         acc_nonsecure,
    input  logic         acc_el3_impl,
    input  logic         acc_g0_secure,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] mask_q,
    output logic         upd_strobe
);
    acc_attr_t    attr;
    logic         xlate;
    logic         we;
    logic         accept;
    logic [W-1:0] nxt;

    always_comb begin
        attr.nonsecure = acc_nonsecure;
        attr.el3_impl  = acc_el3_impl;
        attr.g0_secure = acc_g0_secure;
        we             = acc_valid && acc_write;
    end

    pmask_view_sel u_sel (
        .attr  (attr),
        .xlate (xlate)
    );

    pmask_rd_path #(.W(W)) u_rd (
        .cur   (mask_q),
        .xlate (xlate),
        .rdata (rd_data)
    );

    pmask_wr_path #(.W(W)) u_wr (
        .cur    (mask_q),
        .wdata  (acc_wdata),
        .we     (we),
        .xlate  (xlate),
        .accept (accept),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '0;
            upd_strobe <= 1'b0;
        end else begin
            upd_strobe <= accept;
            if (accept) mask_q <= nxt;
        end
    end

    p_reset_r1: assert property (@(posedge clk) $past(rst) |-> (mask_q == '0 && !upd_strobe));

    p_raw_store_r2: assert property (@(posedge clk) disable iff (rst)
        (we && !(acc_nonsecure && acc_el3_impl && acc_g0_secure)) |=> (mask_q == $past(acc_wdata)));

    p_ns_block_r7: assert property (@(posedge clk) disable iff (rst)
        (we && acc_nonsecure && acc_el3_impl && acc_g0_secure && !mask_q[W-1])
        |=> ($stable(mask_q) && !upd_strobe));

    p_ns_store_r8: assert property (@(posedge clk) disable iff (rst)
        (we && acc_nonsecure && acc_el3_impl && acc_g0_secure && mask_q[W-1])
        |=> (mask_q == {1'b1, $past(acc_wdata[W-1:1])}));

    p_strobe_cause_r9: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |-> $past(we));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(mask_q) && !upd_strobe));
endmodule

// File: tb/sim_pmask_bank.sv
module sim_pmask_bank;
    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid, acc_write;
    logic [7:0] acc_wdata;
    logic       acc_nonsecure, acc_el3_impl, acc_g0_secure;
    logic [7:0] rd_data, mask_q;
    logic       upd_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model;
    bit done = 0;

    always #4 clk = ~clk;

    pmask_bank u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .acc_nonsecure(acc_nonsecure),
        .acc_el3_impl(acc_el3_impl), .acc_g0_secure(acc_g0_secure),
        .rd_data(rd_data), .mask_q(mask_q), .upd_strobe(upd_strobe)
    );

    function automatic logic [7:0] exp_read(logic [7:0] s, logic tr);
        if (!tr) return s;                    // R2
        if (s[7] == 1'b0) return 8'h00;       // R4
        if (s == 8'hFF) return 8'hFF;         // R6
        return {s[6:0], 1'b0};                // R5
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_op(logic wr, logic ns, logic el3, logic g0, logic [7:0] d);
        logic tr;
        logic acc;
        logic [7:0] nxt;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_wdata = d;
        acc_nonsecure = ns; acc_el3_impl = el3; acc_g0_secure = g0;
        tr = ns && el3 && g0;                 // R3
        #1;
        if (!wr) begin
            if (!tr) check("R2/R3 raw read", rd_data, exp_read(model, 1'b0));
            else if (!model[7]) check("R4 hidden read", rd_data, exp_read(model, 1'b1));
            else if (model == 8'hFF) check("R6 top read", rd_data, exp_read(model, 1'b1));
            else check("R5 shifted read", rd_data, exp_read(model, 1'b1));
        end
        acc = wr && (!tr || model[7]);
        nxt = tr ? {1'b1, d[7:1]} : d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        if (acc) model = nxt;
        if (!wr)            check("R10 read keeps mask", mask_q, model);
        else if (!tr)       check("R2 raw write", mask_q, model);
        else if (!acc)      check("R7 blocked write", mask_q, model);
        else                check("R8 translated write", mask_q, model);
        check("R9 strobe", {7'd0, upd_strobe}, {7'd0, acc});
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = 8'h00;
        acc_nonsecure = 1'b0; acc_el3_impl = 1'b0; acc_g0_secure = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model = 8'h00;
        check("R1 reset mask", mask_q, 8'h00);
        check("R1 reset strobe", {7'd0, upd_strobe}, 8'h00);
        @(negedge clk);
        check("R10 idle strobe", {7'd0, upd_strobe}, 8'h00);

        // R7: translated write while mask is in the secure half
        do_op(1, 1, 1, 1, 8'hF0);
        // R3: each attribute cleared alone gives raw access
        do_op(1, 0, 1, 1, 8'h7F);
        do_op(0, 1, 1, 0, 8'h00);
        do_op(0, 1, 0, 1, 8'h00);
        do_op(0, 1, 1, 1, 8'h00);   // R4 with 0x7F
        do_op(1, 1, 1, 0, 8'h80);
        do_op(0, 1, 1, 1, 8'h00);   // R5: 0x80 -> 0x00
        do_op(1, 0, 0, 0, 8'hC3);
        do_op(0, 1, 1, 1, 8'h00);   // R5: 0xC3 -> 0x86
        do_op(1, 1, 1, 1, 8'h55);   // R8: 0xAA
        do_op(1, 1, 1, 1, 8'hFF);   // R8: 0xFF
        do_op(0, 1, 1, 1, 8'h00);   // R6
        do_op(1, 1, 1, 1, 8'h00);   // R8: 0x80

        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            // bias attributes toward the translated view
            do_op(r[0], r[1] | r[3], r[2] | r[3], r[3] | ($urandom % 2 == 0),
                  8'($urandom));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule